// File: doc/BRIEF.md
# Snapshot-Latched 64-bit Cycle Counter

This block keeps a 64-bit free-running count and presents it to software through three 32-bit registers. The count advances by one on each clock cycle in which the `tick_en` input is high. A 32-bit bus cannot read 64 bits in one access, so software gets a consistent value another way. It sets a capture command bit in the control register. In that same cycle, the whole count is copied into a low snapshot word and a high snapshot word. Both words can then be read one at a time without tearing.

A second command bit zeroes both snapshot words. Both command bits drop back to zero by themselves once their action is done. Software may also write either snapshot word directly. Reads come from a combinational multiplexer and never change any state. The block has no interrupt or compare logic.

Register selection uses the 2-bit `addr` input: 0 selects control, 1 selects the low snapshot word, 2 selects the high snapshot word, and 3 is unused.

Top module: `snapctr_top`

## Requirements
- R1: After reset, the control register, the low word and the high word all read zero.
- R2: The internal count rises by exactly one at every clock edge where `tick_en` is high. It holds its value when `tick_en` is low, and wraps from all ones to zero.
- R3: A write to control (addr 0) with bit 1 set and bit 0 clear loads count bits [31:0] into the low word (addr 1) and bits [63:32] into the high word (addr 2). The count used is the one present at that write edge.
- R4: Control bit 1 never reads back as one; after a capture command it reads zero.
- R5: A write to control with bit 0 set zeroes the low and high words, and control bit 0 then reads zero.
- R6: When bits 1 and 0 are both set in one control write, the capture happens first and the clear then wins, so both words read zero.
- R7: Control bits [31:2] are stored exactly as written and trigger no action on the snapshot words.
- R8: A write to addr 1 or addr 2 replaces only that word with the written data.
- R9: Reading any register changes neither the count nor the snapshot words.
- R10: Address 3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable; the count advances on each edge where this is high |
| wr_en | input | 1 | Write strobe for the register selected by `addr` |
| addr | input | 2 | Register select: 0 control, 1 low word, 2 high word, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register selected by `addr` (combinational) |

## Verification
A wrong count shows up only at the next capture command. The captured low word then differs from the number of `tick_en` cycles since reset, so a single capture after a counted run exposes a missed or extra increment. A stuck command bit shows in the first control read after the write. A faulty enable on a snapshot word shows as changed or unchanged data on the very next read of that word. The bench therefore pairs every command with reads in the cycles right after it, and a fault appears within two cycles of the write that provokes it.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CAPTURE_BIT = 1;
  localparam int ZERO_BIT    = 0;

endpackage

// File: rtl/snapctr_rst_sync.sv
module snapctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/snapctr_counter.sv
module snapctr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] count_q;
  logic             count_en;

  always_comb begin
    count_en = tick_en;
    count_d  = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count_q == $past(count_q) + {{(CNT_W-1){1'b0}}, 1'b1}); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count_q)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (&count_q)) |=> count_q == '0); // R2

endmodule

// File: rtl/snapctr_regs.sv
module snapctr_regs
  import snapctr_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  localparam int CNT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [NWORDS-1:0] wr_word,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [WORD_W-1:0] ctl_q,
  output logic [CNT_W-1:0]  snap_q
);

  localparam logic [WORD_W-1:0] CMD_MASK =
    (WORD_W'(1) << CAPTURE_BIT) | (WORD_W'(1) << ZERO_BIT);

  logic capture_cmd;
  logic zero_cmd;
  logic [WORD_W-1:0] ctl_d;
  logic              ctl_en;

  always_comb begin
    capture_cmd = wr_ctl && wdata[CAPTURE_BIT];
    zero_cmd    = wr_ctl && wdata[ZERO_BIT];
    ctl_en      = wr_ctl;
    ctl_d       = wdata & ~CMD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] word_q;
    logic              word_en;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (wr_word[gi]) begin
        word_en = 1'b1;
        word_d  = wdata;
      end
      if (capture_cmd) begin
        word_en = 1'b1;
        word_d  = count[gi*WORD_W +: WORD_W];
      end
      if (zero_cmd) begin
        word_en = 1'b1;
        word_d  = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign snap_q[gi*WORD_W +: WORD_W] = word_q;
  end

  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[CAPTURE_BIT] && !wdata[ZERO_BIT]) |=> snap_q == $past(count)); // R3
  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl_q[CAPTURE_BIT] == 1'b0 && ctl_q[ZERO_BIT] == 1'b0)); // R4
  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[ZERO_BIT]) |=> snap_q == '0); // R6
  AST_SNAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctl && wr_word == '0) |=> $stable(snap_q)); // R9

endmodule

// File: rtl/snapctr_top.sv
module snapctr_top
  import snapctr_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int NWORDS = 2;
  localparam int CNT_W  = WORD_W * NWORDS;

  logic              rst_n_sync;
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] ctl_q;
  logic [CNT_W-1:0]  snap_q;
  logic              wr_ctl;
  logic [NWORDS-1:0] wr_word;
  reg_sel_e          sel;

  snapctr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  snapctr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .tick_en (tick_en),
    .count   (count)
  );

  always_comb begin
    sel        = reg_sel_e'(addr[1:0]);
    wr_ctl     = wr_en && (sel == SEL_CTL);
    wr_word[0] = wr_en && (sel == SEL_LO);
    wr_word[1] = wr_en && (sel == SEL_HI);
  end

  snapctr_regs #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_ctl  (wr_ctl),
    .wr_word (wr_word),
    .wdata   (wdata),
    .count   (count),
    .ctl_q   (ctl_q),
    .snap_q  (snap_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CTL: rdata = ctl_q;
      SEL_LO:  rdata = snap_q[WORD_W-1:0];
      SEL_HI:  rdata = snap_q[CNT_W-1:WORD_W];
      default: rdata = '0;
    endcase
  end

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (sel == SEL_NONE) |-> rdata == '0); // R10
  AST_LO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_word[0] && !wr_ctl) |=> (snap_q[WORD_W-1:0] == $past(wdata)
                                 && $stable(snap_q[CNT_W-1:WORD_W]))); // R8

endmodule

// File: tb/snapctr_top_bench.sv
module snapctr_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  always #5 clk = ~clk;

  snapctr_top u_snapctr_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata)
  );

  typedef struct {
    logic [1:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] model_cnt = '0;
  bit          done = 1'b0;

  // independent model of the count: one per tick_en edge after reset
  always @(posedge clk) if (rst_n && tick_en) model_cnt <= model_cnt + 64'd1;

  // monitor: compares queued expectations with the read port
  always @(negedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    it.a = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic [63:0] cap);
    @(negedge clk);
    cap   = model_cnt;
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [63:0] cap;
    logic [63:0] cap2;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    rd(2'd0, 32'h0, "R1 ctl");
    rd(2'd1, 32'h0, "R1 lo");
    rd(2'd2, 32'h0, "R1 hi");

    tick_en = 1'b1;
    idle(10);
    wr(2'd0, 32'h2, cap);
    rd(2'd1, cap[31:0],  "R3 lo capture");
    rd(2'd2, cap[63:32], "R3 hi capture");
    rd(2'd0, 32'h0,      "R4 capture bit cleared");

    wr(2'd1, 32'h1234_5678, cap2);
    wr(2'd2, 32'hDEAD_BEEF, cap2);
    rd(2'd1, 32'h1234_5678, "R8 lo write");
    rd(2'd2, 32'hDEAD_BEEF, "R8 hi write");
    wr(2'd3, 32'hFFFF_FFFF, cap2);
    rd(2'd3, 32'h0,         "R10 unused addr");
    rd(2'd1, 32'h1234_5678, "R10 lo untouched");
    rd(2'd2, 32'hDEAD_BEEF, "R10 hi untouched");
    rd(2'd0, 32'h0,         "R10 ctl untouched");

    wr(2'd0, 32'h2, cap);
    rd(2'd1, cap[31:0],  "R3 lo recapture");
    rd(2'd2, cap[63:32], "R3 hi overwritten by capture");

    tick_en = 1'b0;
    wr(2'd0, 32'h2, cap);
    idle(6);
    wr(2'd0, 32'h2, cap2);
    rd(2'd1, cap[31:0], "R2 hold while tick_en low");
    tick_en = 1'b1;
    idle(7);
    wr(2'd0, 32'h2, cap2);
    rd(2'd1, cap[31:0] + 32'd8, "R2 count step per tick");

    wr(2'd0, 32'h1, cap2);
    rd(2'd1, 32'h0, "R5 lo zeroed");
    rd(2'd2, 32'h0, "R5 hi zeroed");
    rd(2'd0, 32'h0, "R5 zero bit cleared");

    wr(2'd1, 32'hA5A5_A5A5, cap2);
    wr(2'd2, 32'h5A5A_5A5A, cap2);
    wr(2'd0, 32'h3, cap2);
    rd(2'd1, 32'h0, "R6 lo both bits");
    rd(2'd2, 32'h0, "R6 hi both bits");

    wr(2'd1, 32'h0000_BEEF, cap2);
    wr(2'd0, 32'hFFFF_FFFC, cap2);
    rd(2'd0, 32'hFFFF_FFFC, "R7 upper bits stored");
    rd(2'd1, 32'h0000_BEEF, "R7 upper bits no action");
    wr(2'd0, 32'hABCD_0006, cap2);
    rd(2'd0, 32'hABCD_0004, "R4 R7 mixed control");

    wr(2'd0, 32'h2, cap);
    rd(2'd1, cap[31:0], "R9 read 1");
    rd(2'd1, cap[31:0], "R9 read 2");
    rd(2'd2, cap[63:32], "R9 read hi");
    rd(2'd1, cap[31:0], "R9 read 3");
    wr(2'd0, 32'h2, cap);
    rd(2'd1, cap[31:0], "R9 count unaffected by reads");

    idle(3);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule